// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block is the transmit side of a clocked serial port that acts as bus master. A host writes bytes, plus an optional ninth bit, into a single holding buffer. Whenever the internal shifter is free, the waiting word moves into it and leaves on a data line, least significant bit first. The block drives the matching bit clock on a clock line. The shifter reloads straight from the buffer as the last bit of a word finishes, so a steady stream of writes produces an unbroken clock and data stream.

Two status outputs report progress. `buf_empty` is high while the holding buffer has room. It falls only when the host writes and rises only when the word moves into the shifter. `shift_empty` is a poll-only indication that the shifter holds nothing. A 16-bit divisor sets the bit rate. A polarity input selects whether the clock idles low or high. Dropping the enable aborts any word in flight.

Top module: `sync_ser_tx`

## Requirements
- R1: `buf_empty` is 1 after reset. It goes to 0 in the cycle after `wr_stb` is sampled high and returns to 1 only when the buffered word moves into the shifter. Nothing else clears the buffer.
- R2: With `tx_en` high and the shifter empty, a buffered word moves into the shifter on the next clock edge. `shift_empty` falls and `buf_empty` rises in the same cycle.
- R3: Each half of the bit clock lasts `baud_div`+1 cycles, so one bit lasts 2*(`baud_div`+1) cycles. A divisor of 0 gives a 2-cycle bit.
- R4: The data bits go out least significant first, bit 0 through bit 7.
- R5: When `word9_en` is 1 at the moment a word enters the shifter, the `wr_bit9` value captured with that word is sent as a ninth bit after bit 7.
- R6: `ser_clk` rests at the level of `clk_idle_hi` (1 = idle high, 0 = idle low) whenever no bit is in its active half.
- R7: `ser_dat` changes only on the `ser_clk` edge that leaves the idle level. It stays constant across the edge that returns to idle.
- R8: If a word is waiting when the last bit of the current word returns to idle, it loads at once, and its bit 0 leaves after the same half-period spacing as any other bit.
- R9: `shift_empty` is 1 exactly when the shifter holds no word. `tx_active`, which inhibits the receiver, is its complement.
- R10: When `tx_en` is sampled low, the shifter empties in the next cycle: `ser_clk` goes to idle, `ser_dat` goes to 0 and `shift_empty` goes to 1. The holding buffer keeps its contents.
- R11: After reset `shift_empty`=1, `tx_active`=0, `ser_dat`=0 and `ser_clk` equals `clk_idle_hi`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; low aborts and empties the shifter |
| word9_en | input | 1 | Send a ninth bit with each word |
| clk_idle_hi | input | 1 | Idle level of the bit clock |
| baud_div | input | 16 | Half-period divisor; half period = value + 1 cycles |
| wr_stb | input | 1 | Write strobe into the holding buffer |
| wr_data | input | 8 | Data byte to buffer |
| wr_bit9 | input | 1 | Ninth bit captured with the byte |
| buf_empty | output | 1 | Holding buffer has room |
| shift_empty | output | 1 | Shifter holds no word |
| tx_active | output | 1 | Transmitter busy; receive inhibit |
| ser_clk | output | 1 | Serial bit clock |
| ser_dat | output | 1 | Serial data |

## Verification
A behavioural model of the port, built on integers, is stepped alongside the design and compared every cycle. The stimulus covers a single 8-bit word at the fastest divisor, which exposes bit order and the shortest bit timing. A 9-bit word with clock idling high and a slower divisor separates the ninth-bit path and the polarity from the plain case. Two writes issued back to back show whether the reload leaves a gap at the word boundary. A write made while disabled, followed by a mid-word abort, confirms that the buffer flag responds only to writes and transfers and that an abort clears only the shifter.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned WORD_W = DATA_W + 1;
    localparam int unsigned LEFT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        logic              busy;
        logic              act;
        logic              dat;
        logic [LEFT_W-1:0] left;
        logic [WORD_W-1:0] sh;
    } shf_t;

    typedef struct packed {
        logic              full;
        logic [WORD_W-1:0] word;
    } hold_t;
endpackage

// File: rtl/sstx_baud.sv
module sstx_baud #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = '0;
        if (run && !tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3
    half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/sstx_hold.sv
module sstx_hold
    import sstx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] word
);
    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (take) h_d.full = 1'b0;
        if (wr_stb) begin
            h_d.full = 1'b1;
            h_d.word = {wr_bit9, wr_data};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign full = h_q.full;
    assign word = h_q.word;

    // R1
    fill_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h_q.full) |-> $past(wr_stb));
    // R1
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> h_q.full);
endmodule

// File: rtl/sstx_shift.sv
module sstx_shift
    import sstx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              nine,
    output logic              busy,
    output logic              act,
    output logic              dat,
    output logic              done
);
    shf_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = tick && s_q.act && (s_q.left == LEFT_W'(1));
        if (!en) begin
            s_d = '0;
        end else begin
            if (tick && !s_q.act) begin
                s_d.act = 1'b1;
                s_d.dat = s_q.sh[0];
            end else if (tick && s_q.act) begin
                s_d.act  = 1'b0;
                s_d.sh   = s_q.sh >> 1;
                s_d.left = s_q.left - 1'b1;
                if (done) s_d.busy = 1'b0;
            end
            if (load) begin
                s_d.busy = 1'b1;
                s_d.act  = 1'b0;
                s_d.sh   = load_word;
                s_d.left = nine ? LEFT_W'(WORD_W) : LEFT_W'(DATA_W);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign act  = s_q.act;
    assign dat  = s_q.dat;

    // R7
    dat_on_leave_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        ($past(en) && !$rose(s_q.act)) |-> $stable(s_q.dat));
    // R9
    act_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.act |-> s_q.busy);
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
    import sstx_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             word9_en,
    input  logic             clk_idle_hi,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             wr_stb,
    input  logic [7:0]       wr_data,
    input  logic             wr_bit9,
    output logic             buf_empty,
    output logic             shift_empty,
    output logic             tx_active,
    output logic             ser_clk,
    output logic             ser_dat
);
    logic              tick, load, hold_full, busy, act, done;
    logic [WORD_W-1:0] hold_word;

    sstx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy && tx_en), .div(baud_div), .tick(tick)
    );

    sstx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .wr_bit9(wr_bit9), .take(load), .full(hold_full), .word(hold_word)
    );

    sstx_shift u_shift (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .tick(tick), .load(load),
        .load_word(hold_word), .nine(word9_en), .busy(busy), .act(act),
        .dat(ser_dat), .done(done)
    );

    assign load        = tx_en && hold_full && (!busy || done);
    assign buf_empty   = !hold_full;
    assign shift_empty = !busy;
    assign tx_active   = busy;
    assign ser_clk     = act ^ clk_idle_hi;

    // R2
    transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && hold_full && !busy && !wr_stb) |=> (!shift_empty && buf_empty));
    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (shift_empty && !ser_dat && ser_clk == clk_idle_hi));
endmodule

// File: tb/tb_sync_ser_tx.sv
module tb_sync_ser_tx;
    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_en = 1'b0, word9_en = 1'b0, clk_idle_hi = 1'b0;
    logic [15:0] baud_div = '0;
    logic wr_stb = 1'b0, wr_bit9 = 1'b0;
    logic [7:0] wr_data = '0;
    logic buf_empty, shift_empty, tx_active, ser_clk, ser_dat;

    always #5 clk = ~clk;

    sync_ser_tx dut (.*);

    int vec = 0, bad = 0, cyc = 0;
    int lt[$];
    bit lb[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural reference
    bit m_full, m_busy, m_act, m_dat;
    int m_hold, m_word, m_cnt, m_idx, m_nbits;

    always @(posedge clk) begin
        bit tick, done, ld;
        cyc++;
        if (!rst_n) begin
            m_full = 0; m_busy = 0; m_act = 0; m_dat = 0; m_cnt = 0;
            m_hold = 0; m_word = 0; m_idx = 0; m_nbits = 0;
        end else begin
            tick = m_busy && tx_en && (m_cnt == int'(baud_div));
            done = 0;
            ld = 0;
            if (!tx_en) begin
                m_busy = 0; m_act = 0; m_dat = 0; m_cnt = 0;
            end else begin
                if (m_busy) m_cnt = tick ? 0 : m_cnt + 1;
                if (tick && !m_act) begin
                    m_act = 1; m_dat = m_word[m_idx];
                end else if (tick && m_act) begin
                    m_act = 0; m_idx++;
                    if (m_idx == m_nbits) done = 1;
                end
                if (m_full && (!m_busy || done)) begin
                    ld = 1;
                    m_word = m_hold; m_idx = 0; m_nbits = word9_en ? 9 : 8;
                    m_busy = 1; m_cnt = 0;
                end else if (done) begin
                    m_busy = 0; m_cnt = 0;
                end
            end
            if (ld) m_full = 0;
            if (wr_stb) begin
                m_full = 1; m_hold = {23'd0, wr_bit9, wr_data};
            end
        end
    end

    // per-cycle compare and monitor
    bit prev_on = 0, prev_dat = 0, have_prev = 0;
    always @(posedge clk) begin
        bit on;
        #2;
        if (rst_n) begin
            chk(buf_empty == !m_full, "R1 buf_empty", buf_empty, !m_full);
            chk(shift_empty == !m_busy, "R9 shift_empty", shift_empty, !m_busy);
            chk(tx_active == m_busy, "R9 tx_active", tx_active, m_busy);
            chk(ser_clk == (m_act ^ clk_idle_hi), "R6 ser_clk", ser_clk, m_act ^ clk_idle_hi);
            chk(ser_dat == m_dat, "R4 ser_dat", ser_dat, m_dat);
            on = (ser_clk != clk_idle_hi);
            if (on && !prev_on) begin
                lt.push_back(cyc); lb.push_back(ser_dat);
            end
            if (have_prev && tx_en && ser_dat != prev_dat)
                chk(on && !prev_on, "R7 data change off leave edge", 0, 1);
            prev_on = on; prev_dat = ser_dat; have_prev = 1;
        end
    end

    task automatic wr(input logic [7:0] d, input logic b9);
        @(negedge clk); wr_stb = 1; wr_data = d; wr_bit9 = b9;
        @(negedge clk); wr_stb = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (shift_empty && buf_empty) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        logic [15:0] two;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(posedge clk); #4;
        // R11 reset state
        chk(buf_empty == 1, "R11 buf_empty", buf_empty, 1);
        chk(shift_empty == 1 && tx_active == 0, "R11 shift_empty", shift_empty, 1);
        chk(ser_clk == 0 && ser_dat == 0, "R11 ser_clk/ser_dat", {ser_clk, ser_dat}, 0);

        // R1: write while disabled stays buffered
        @(negedge clk); tx_en = 0;
        wr(8'h5A, 0);
        repeat (5) @(negedge clk);
        chk(buf_empty == 0 && shift_empty == 1, "R1 held while disabled", buf_empty, 0);
        tx_en = 1;
        wait_idle();

        // R4 and R3 at fastest rate
        lt.delete(); lb.delete();
        wr(8'hA5, 0);
        wait_idle();
        chk(lb.size() == 8, "R4 bit count", lb.size(), 8);
        for (int i = 0; i < lb.size() && i < 8; i++)
            chk(lb[i] == ((8'hA5 >> i) & 1), "R4 bit order", lb[i], (8'hA5 >> i) & 1);
        for (int i = 1; i < lt.size(); i++)
            chk(lt[i] - lt[i-1] == 2, "R3 period div0", lt[i] - lt[i-1], 2);

        // R5 and R6: ninth bit, idle high, divisor 3
        @(negedge clk); clk_idle_hi = 1; word9_en = 1; baud_div = 3;
        lt.delete(); lb.delete();
        wr(8'h3C, 1);
        wait_idle();
        chk(ser_clk == 1, "R6 idle high", ser_clk, 1);
        chk(lb.size() == 9, "R5 bit count", lb.size(), 9);
        if (lb.size() == 9) chk(lb[8] == 1, "R5 ninth bit", lb[8], 1);
        for (int i = 1; i < lt.size(); i++)
            chk(lt[i] - lt[i-1] == 8, "R3 period div3", lt[i] - lt[i-1], 8);

        // R8: back-to-back words
        @(negedge clk); clk_idle_hi = 0; word9_en = 0; baud_div = 1;
        lt.delete(); lb.delete();
        wr(8'hC3, 0);
        wr(8'h96, 0);
        wait_idle();
        chk(lb.size() == 16, "R8 bit count", lb.size(), 16);
        two = 16'h96C3;
        for (int i = 0; i < lb.size() && i < 16; i++)
            chk(lb[i] == two[i], "R8 chained bits", lb[i], two[i]);
        for (int i = 1; i < lt.size(); i++)
            chk(lt[i] - lt[i-1] == 4, "R8 no gap", lt[i] - lt[i-1], 4);

        // R2 transfer timing, then R10 abort
        @(negedge clk); wr_stb = 1; wr_data = 8'hFF; wr_bit9 = 0;
        @(posedge clk); #4;
        chk(buf_empty == 0 && shift_empty == 1, "R2 buffered", {buf_empty, shift_empty}, 1);
        @(negedge clk); wr_stb = 0;
        @(posedge clk); #4;
        chk(buf_empty == 1 && shift_empty == 0, "R2 transferred", {buf_empty, shift_empty}, 2);
        repeat (7) @(negedge clk);
        tx_en = 0;
        @(posedge clk); #4;
        chk(shift_empty == 1 && tx_active == 0, "R10 shifter emptied", shift_empty, 1);
        chk(ser_clk == clk_idle_hi && ser_dat == 0, "R10 lines idle", {ser_clk, ser_dat}, 0);
        @(negedge clk); tx_en = 1;
        repeat (6) @(negedge clk);
        chk(buf_empty == 1 && shift_empty == 1, "R1 no spurious refill", buf_empty, 1);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule